// File: doc/BRIEF.md
# Per-Phase Apparent Power Gain Datapath

The block turns per-phase rms voltage and rms current values into total apparent power for three phases, then trims each phase with its own signed gain. One sample strobe carries all six rms values; the block captures them and works through the phases in a fixed order on one shared multiplier. After each phase it loads that phase's result register and pulses that phase's strobe.

The three gain trims sit in a small register file behind a 32-bit word port. Each trim is a 24-bit two's-complement fraction. Internally it is widened to the 28-bit datapath. A trim is applied as a factor of one plus the trim. The block adds no offset term to apparent power; offsets belong to the rms stages upstream.

Top module: `phase_va_gain`

## Requirements
- R1: For phase p (0 = A, 1 = B, 2 = C), V = `vrms_i[24p+23:24p]` and I = `irms_i[24p+23:24p]`, both unsigned. The untrimmed power is floor(V*I / 2^21).
- R2: The phase output `va_o[28p+27:28p]` equals floor(base*(2^23 + g) / 2^23), where base is the R1 value and g is that phase's trim read as signed 24-bit. A trim of zero passes the base unchanged.
- R3: A trim of 0xC00000 yields half the base, rounded down. A trim of 0x400000 yields 1.5 times the base, rounded down.
- R4: A result above 2^27-1 is clamped to 2^27-1 (0x7FFFFFF). An output never has bit 27 set.
- R5: A write with `reg_addr_i` 0, 1 or 2 loads trim A, B or C from `reg_wdata_i[23:0]`. Bits 31:24 of the write word have no effect.
- R6: A read returns {4'b0, four copies of trim bit 23, trim[23:0]}. Address 3 reads as zero, and a write to address 3 changes no trim.
- R7: After reset, all trims read zero, all outputs are zero and no strobe is high.
- R8: For a sample accepted at clock edge k, `va_valid_o[0]`, `[1]` and `[2]` pulse for one cycle after edges k+2, k+4 and k+6. At most one strobe bit is high at a time.
- R9: The trims are captured when a sample is accepted. A trim write made while that sample is in progress leaves its results unchanged and applies from the next sample.
- R10: A sample strobe that arrives while a sample is in progress is ignored. The next sample can be accepted from edge k+7.
- R11: Each phase output holds its value in every cycle in which its strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Sample strobe for the rms inputs |
| vrms_i | input | 72 | Per-phase rms voltage, 24 bits per phase, A in the low bits |
| irms_i | input | 72 | Per-phase rms current, 24 bits per phase, A in the low bits |
| reg_we_i | input | 1 | Trim register write enable |
| reg_addr_i | input | 2 | Trim register address (0 A, 1 B, 2 C) |
| reg_wdata_i | input | 32 | Trim register write data |
| reg_rdata_o | output | 32 | Trim register read data, combinational from the address |
| va_o | output | 84 | Per-phase apparent power, 28 bits per phase, A in the low bits |
| va_valid_o | output | 3 | Per-phase result strobe |

## Verification
The bench goes after several corner cases:
- Full-scale inputs with a positive trim. A design without the clamp would wrap these into a negative or small output.
- The half and one-and-a-half trims. A sign-extension error would turn 0xC00000 into a large positive gain.
- A trim write landing mid-sample. Without the capture at accept, phase C would pick up the new factor too early.
- A second strobe arriving while a sample is busy. A design that restarted on it would emit extra or reordered phase strobes.
- Register writes with junk in the upper byte, and writes to the empty address. A design that stored too many bits, or that decoded address 3, would read back wrong values.

// File: rtl/va_pkg.sv
package va_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_VI   = 2'd1,
    ST_GAIN = 2'd2
  } va_st_e;
endpackage

// File: rtl/va_gain_regs.sv
module va_gain_regs #(
  parameter int N_PH   = 3,
  parameter int GAIN_W = 24,
  parameter int DP_W   = 28,
  parameter int BUS_W  = 32,
  localparam int ADDR_W = (N_PH > 1) ? $clog2(N_PH + 1) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [BUS_W-1:0]       wdata_i,
  output logic [BUS_W-1:0]       rdata_o,
  output logic [N_PH*DP_W-1:0]   gain_o
);
  logic [N_PH-1:0][GAIN_W-1:0] gain_q;
  logic [N_PH-1:0][DP_W-1:0]   gain_ext;
  logic unused_wd;

  assign unused_wd = ^wdata_i[BUS_W-1:GAIN_W];

  for (genvar p = 0; p < N_PH; p++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              gain_q[p] <= '0;
      else if (we_i && addr_i == ADDR_W'(p))    gain_q[p] <= wdata_i[GAIN_W-1:0];
    end
    assign gain_ext[p] = {{(DP_W-GAIN_W){gain_q[p][GAIN_W-1]}}, gain_q[p]};
    assign gain_o[p*DP_W +: DP_W] = gain_ext[p];

    // R5
    gain_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_i && addr_i == ADDR_W'(p) |=>
        gain_o[p*DP_W +: DP_W] == DP_W'($signed($past(wdata_i[GAIN_W-1:0]))));
  end

  always_comb begin
    rdata_o = '0;
    for (int p = 0; p < N_PH; p++)
      if (addr_i == ADDR_W'(p)) rdata_o = {{(BUS_W-DP_W){1'b0}}, gain_ext[p]};
  end

  // R6
  gain_unmapped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i >= ADDR_W'(N_PH) |=> $stable(gain_o));
endmodule

// File: rtl/va_mul.sv
module va_mul #(
  parameter int A_W = 28,
  parameter int B_W = 25,
  localparam int P_W = A_W + B_W
) (
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  output logic [P_W-1:0] p_o
);
  assign p_o = P_W'(a_i) * P_W'(b_i);
endmodule

// File: rtl/va_post.sv
module va_post #(
  parameter int RMS_W  = 24,
  parameter int DP_W   = 28,
  parameter int FRAC   = 23,
  parameter int PROD_W = 53,
  localparam int VI_SHIFT = 2*RMS_W - (DP_W-1)
) (
  input  logic [PROD_W-1:0] prod_i,
  input  logic              gain_step_i,
  output logic [DP_W-1:0]   res_o
);
  logic [PROD_W-1:0] scaled;
  logic [PROD_W-1:0] sat_max;
  logic              unused_lo;

  assign unused_lo = ^prod_i[VI_SHIFT-1:0];
  // floor: drop fractional bits
  assign scaled  = prod_i >> FRAC;
  assign sat_max = PROD_W'({1'b0, {(DP_W-1){1'b1}}});

  always_comb begin
    if (gain_step_i) res_o = (scaled > sat_max) ? sat_max[DP_W-1:0] : scaled[DP_W-1:0];
    else             res_o = prod_i[VI_SHIFT +: DP_W];
  end
endmodule

// File: rtl/va_seq.sv
module va_seq
  import va_pkg::*;
#(
  parameter int N_PH  = 3,
  parameter int RMS_W = 24,
  parameter int DP_W  = 28,
  parameter int FRAC  = 23,
  localparam int MA_W   = (RMS_W > DP_W) ? RMS_W : DP_W,
  localparam int MB_W   = (RMS_W > FRAC+2) ? RMS_W : FRAC+2,
  localparam int PROD_W = MA_W + MB_W,
  localparam int PH_W   = (N_PH > 1) ? $clog2(N_PH) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  smp_valid_i,
  input  logic [N_PH*RMS_W-1:0] vrms_i,
  input  logic [N_PH*RMS_W-1:0] irms_i,
  input  logic [N_PH*DP_W-1:0]  gain_i,
  output logic [DP_W-1:0]       res_o,
  output logic [N_PH-1:0]       res_we_o
);
  va_st_e                       st_q;
  logic [PH_W-1:0]              ph_q;
  logic [N_PH-1:0][RMS_W-1:0]   v_sh, i_sh;
  logic [N_PH-1:0][DP_W-1:0]    g_sh;
  logic [DP_W-1:0]              base_q, factor, post_res;
  logic [MA_W-1:0]              op_a;
  logic [MB_W-1:0]              op_b;
  logic [PROD_W-1:0]            prod;
  logic                         accept, last_ph, gain_step, unused_fac;

  assign accept    = smp_valid_i && st_q == ST_IDLE;
  assign last_ph   = ph_q == PH_W'(N_PH-1);
  assign gain_step = st_q == ST_GAIN;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ph_q   <= '0;
      base_q <= '0;
      g_sh   <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          st_q <= ST_VI;
          ph_q <= '0;
          g_sh <= gain_i;
        end
        ST_VI: begin
          base_q <= post_res;
          st_q   <= ST_GAIN;
        end
        ST_GAIN: begin
          if (last_ph) st_q <= ST_IDLE;
          else begin
            st_q <= ST_VI;
            ph_q <= ph_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar p = 0; p < N_PH; p++) begin : g_cap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_sh[p] <= '0;
        i_sh[p] <= '0;
      end else if (accept) begin
        v_sh[p] <= vrms_i[p*RMS_W +: RMS_W];
        i_sh[p] <= irms_i[p*RMS_W +: RMS_W];
      end
    end
    assign res_we_o[p] = gain_step && ph_q == PH_W'(p);
  end

  // 1 + g, always in [0, 2^(FRAC+1))
  assign factor     = g_sh[ph_q] + DP_W'(1 << FRAC);
  assign unused_fac = ^factor[DP_W-1:MB_W];

  always_comb begin
    if (gain_step) begin
      op_a = MA_W'(base_q);
      op_b = factor[MB_W-1:0];
    end else begin
      op_a = MA_W'(v_sh[ph_q]);
      op_b = MB_W'(i_sh[ph_q]);
    end
  end

  va_mul #(.A_W(MA_W), .B_W(MB_W)) mul_i (
    .a_i(op_a), .b_i(op_b), .p_o(prod)
  );

  va_post #(.RMS_W(RMS_W), .DP_W(DP_W), .FRAC(FRAC), .PROD_W(PROD_W)) post_i (
    .prod_i(prod), .gain_step_i(gain_step), .res_o(post_res)
  );

  assign res_o = post_res;

  // R10
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q != ST_IDLE && smp_valid_i |=> !(st_q == ST_VI && ph_q == '0));

  // R9
  gain_snap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q != ST_IDLE |=> $stable(g_sh));

  // R8
  res_we_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(res_we_o));
endmodule

// File: rtl/phase_va_gain.sv
module phase_va_gain #(
  parameter int N_PH   = 3,
  parameter int RMS_W  = 24,
  parameter int DP_W   = 28,
  parameter int GAIN_W = 24,
  parameter int BUS_W  = 32,
  localparam int FRAC   = GAIN_W - 1,
  localparam int ADDR_W = (N_PH > 1) ? $clog2(N_PH + 1) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  smp_valid_i,
  input  logic [N_PH*RMS_W-1:0] vrms_i,
  input  logic [N_PH*RMS_W-1:0] irms_i,
  input  logic                  reg_we_i,
  input  logic [ADDR_W-1:0]     reg_addr_i,
  input  logic [BUS_W-1:0]      reg_wdata_i,
  output logic [BUS_W-1:0]      reg_rdata_o,
  output logic [N_PH*DP_W-1:0]  va_o,
  output logic [N_PH-1:0]       va_valid_o
);
  logic [N_PH*DP_W-1:0] gain;
  logic [DP_W-1:0]      res;
  logic [N_PH-1:0]      res_we;

  va_gain_regs #(.N_PH(N_PH), .GAIN_W(GAIN_W), .DP_W(DP_W), .BUS_W(BUS_W)) regs_i (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .gain_o(gain)
  );

  va_seq #(.N_PH(N_PH), .RMS_W(RMS_W), .DP_W(DP_W), .FRAC(FRAC)) seq_i (
    .clk_i, .rst_ni,
    .smp_valid_i, .vrms_i, .irms_i,
    .gain_i(gain), .res_o(res), .res_we_o(res_we)
  );

  for (genvar p = 0; p < N_PH; p++) begin : g_out
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        va_o[p*DP_W +: DP_W] <= '0;
        va_valid_o[p]        <= 1'b0;
      end else begin
        va_valid_o[p] <= res_we[p];
        if (res_we[p]) va_o[p*DP_W +: DP_W] <= res;
      end
    end

    // R11
    va_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !va_valid_o[p] |-> $stable(va_o[p*DP_W +: DP_W]));

    // R4
    va_no_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !va_o[p*DP_W + DP_W - 1]);

    if (p < N_PH - 1) begin : g_ord
      // R8
      va_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        va_valid_o[p] |=> ##1 va_valid_o[p+1]);
    end
  end

  // R8
  va_valid_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(va_valid_o));
endmodule

// File: tb/phase_va_gain_tb_top.sv
`timescale 1ns/1ps
module phase_va_gain_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        smp_valid_i = 1'b0;
  logic [71:0] vrms_i = '0;
  logic [71:0] irms_i = '0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [83:0] va_o;
  logic [2:0]  va_valid_o;

  phase_va_gain dut_i (.*);

  always #2 clk_i = ~clk_i;

  typedef struct {
    int     ph;
    longint val;
    longint due;
    string  req;
  } exp_t;

  exp_t        sb_q[$];
  int          total = 0;
  int          bad = 0;
  longint      cyc = 0;
  logic [23:0] gmodel [3];
  longint      last_exp [3];

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  function automatic longint exp_va(longint v, longint i, logic [23:0] g);
    longint base, r;
    base = (v * i) >>> 21;
    r = (base * (longint'(8388608) + longint'($signed(g)))) >>> 23;
    if (r > 134217727) r = 134217727;
    return r;
  endfunction

  function automatic logic [31:0] rd_exp(logic [23:0] g);
    return {4'h0, {4{g[23]}}, g};
  endfunction

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk_i);
      smp_valid_i = 1'b0;
      reg_we_i = 1'b0;
    end
  endtask

  task automatic drive_sample(logic [23:0] va, logic [23:0] ia, logic [23:0] vb,
                              logic [23:0] ib, logic [23:0] vc, logic [23:0] ic,
                              bit push, string req);
    @(negedge clk_i);
    reg_we_i = 1'b0;
    vrms_i = {vc, vb, va};
    irms_i = {ic, ib, ia};
    smp_valid_i = 1'b1;
    if (push) begin
      sb_q.push_back('{0, exp_va(va, ia, gmodel[0]), cyc + 3, req});
      sb_q.push_back('{1, exp_va(vb, ib, gmodel[1]), cyc + 5, req});
      sb_q.push_back('{2, exp_va(vc, ic, gmodel[2]), cyc + 7, req});
    end
  endtask

  task automatic reg_write(logic [1:0] a, logic [31:0] d);
    @(negedge clk_i);
    smp_valid_i = 1'b0;
    reg_we_i = 1'b1;
    reg_addr_i = a;
    reg_wdata_i = d;
    if (a < 2'd3) gmodel[a] = d[23:0];
  endtask

  task automatic reg_read(logic [1:0] a, output logic [31:0] d);
    @(negedge clk_i);
    smp_valid_i = 1'b0;
    reg_we_i = 1'b0;
    reg_addr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  // monitor: pops expected results as strobes appear
  always begin
    @(negedge clk_i);
    if (rst_ni) begin
      for (int p = 0; p < 3; p++) begin
        if (va_valid_o[p]) begin
          if (sb_q.size() == 0) begin
            chk(1'b0, "R10 unexpected strobe", p, -1);
          end else begin
            exp_t it;
            it = sb_q.pop_front();
            chk(it.ph == p, "R8 phase order", p, it.ph);
            chk(cyc == it.due, "R8 strobe cycle", cyc, it.due);
            chk(va_o[p*28 +: 28] == it.val[27:0], it.req, va_o[p*28 +: 28], it.val);
            last_exp[p] = it.val;
          end
        end
      end
    end
  end

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    for (int p = 0; p < 3; p++) begin
      gmodel[p] = '0;
      last_exp[p] = 0;
    end
    idle(3);
    rst_ni = 1'b1;
    idle(1);

    // R7 reset state
    chk(va_o == '0, "R7 outputs", va_o, 0);
    chk(va_valid_o == '0, "R7 strobes", va_valid_o, 0);
    for (int p = 0; p < 3; p++) begin
      reg_read(2'(p), rd);
      chk(rd == 32'h0, "R7 trim", rd, 0);
    end

    // R1 R2 zero trim
    drive_sample(24'h800000, 24'h800000, 24'h123456, 24'h654321, 24'h000000, 24'hFFFFFF, 1, "R1");
    idle(6);
    drive_sample(24'h000001, 24'h000001, 24'hABCDEF, 24'h000FFF, 24'h7FFFFF, 24'h400001, 1, "R2");
    idle(6);

    // R5 R6 register port
    reg_write(2'd0, 32'hFFC00000);
    reg_write(2'd1, 32'hAB400000);
    reg_write(2'd3, 32'h00FFFFFF);
    reg_read(2'd0, rd);
    chk(rd == 32'h0FC00000, "R6 sign extension", rd, 32'h0FC00000);
    reg_read(2'd1, rd);
    chk(rd == rd_exp(24'h400000), "R5 upper byte ignored", rd, rd_exp(24'h400000));
    reg_read(2'd2, rd);
    chk(rd == 32'h0, "R6 addr 3 write no effect", rd, 0);
    reg_read(2'd3, rd);
    chk(rd == 32'h0, "R6 addr 3 reads zero", rd, 0);

    // R3 half and one-and-a-half
    drive_sample(24'h800000, 24'h800000, 24'h800000, 24'h800000, 24'h123457, 24'h0FEDCB, 1, "R3");
    idle(6);

    // R4 saturation
    reg_write(2'd0, 32'h007FFFFF);
    reg_write(2'd2, 32'h00000001);
    reg_read(2'd0, rd);
    chk(rd == rd_exp(24'h7FFFFF), "R5 trim A", rd, rd_exp(24'h7FFFFF));
    drive_sample(24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF, 1, "R4");
    idle(6);

    // R9 trim write during a sample
    drive_sample(24'h600000, 24'h600000, 24'h300000, 24'h200000, 24'h456789, 24'h765432, 1, "R9 old trim");
    reg_write(2'd2, 32'h00C00000);
    idle(5);
    drive_sample(24'h600000, 24'h600000, 24'h300000, 24'h200000, 24'h456789, 24'h765432, 1, "R9 new trim");
    idle(6);

    // R10 strobe while busy is ignored
    drive_sample(24'h111111, 24'h222222, 24'h333333, 24'h444444, 24'h555555, 24'h666666, 1, "R10 first");
    idle(2);
    drive_sample(24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF, 0, "R10");
    idle(4);
    drive_sample(24'h0ABCDE, 24'h0EDCBA, 24'h00F00F, 24'h0FF0FF, 24'h7654FF, 24'h7654FF, 1, "R10 next");
    idle(6);

    for (int w = 0; w < 50 && sb_q.size() != 0; w++) idle(1);
    chk(sb_q.size() == 0, "R8 all phases produced", sb_q.size(), 0);

    // R11 hold
    idle(5);
    for (int p = 0; p < 3; p++)
      chk(va_o[p*28 +: 28] == last_exp[p][27:0], "R11 hold", va_o[p*28 +: 28], last_exp[p]);
    chk(va_valid_o == '0, "R11 strobes idle", va_valid_o, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule